// File: doc/BRIEF.md
# Audio Frame Transmitter

This block takes audio sample words from a one-entry holding register and shifts them out, one bit per bit-clock strobe, as two-slot stereo frames. Its word-select output is low for the left slot and high for the right slot. A three-bit length code sets how many sample bits go out per slot. A slot-width flag picks a 24-bit or a 32-bit slot for the 18-, 20- and 24-bit codes. Two of the codes pack a left and a right sample into one word.

An upstream agent offers words over a valid/ready handshake. A fresh word is taken from the holding register only at the start of a slot. If the register is empty at that moment, the slot is filled with zero or with the word sent in the previous slot, and the block pulses an underrun strobe together with the slot index. A mono option repeats each left sample in the right slot. A loopback option feeds the serial output back into the receive-side serial input. The configuration inputs are held steady while the block runs and are changed only under reset.

Top module: `atx_frame_tx`

## Requirements
- R1: Sample length by `len_code_i`: 0=32, 1=24, 2=20, 3=18, 4=16, 5=16 packed, 6=8, 7=8 packed. The sample sits in the low bits of its word and goes out MSB first. Slot bits after the sample are 0.
- R2: Slot width in bits: code 0 is 32; codes 1-3 are 24 when `slot24_i`=1, otherwise 32; codes 4-5 are 16; codes 6-7 are 8. `ws_o` is 0 during the left slot and 1 during the right slot, and the slots alternate, starting with left after reset.
- R3: With `fmt_lj_i`=1 the MSB goes out on the first bit of the slot, aligned with the `ws_o` change. With `fmt_lj_i`=0 it goes out one bit later, and the first bit of a slot carries the last slot bit of the previous slot's word.
- R4: With `mono_i`=1 the right slot repeats the left slot's word and takes nothing from the holding register.
- R5: In the packed codes (5, 7) one word carries the left sample in bits [L-1:0] and the right sample in bits [2L-1:L]. The right slot takes nothing from the holding register.
- R6: An empty holding register at the start of a left slot, or of a right slot that is neither mono nor packed, is an underrun. `urun_o` pulses for one cycle with `urun_slot_o` equal to that slot's `ws_o`. The slot carries zero when `fill_prev_i`=0 and the previous slot's word when it is 1. A following mono or packed right slot repeats the fill word.
- R7: `rx_sdi_o` equals `sdo_o` when `loop_i`=1, and `sdi_i` otherwise.
- R8: `smp_ready_o` is high exactly while the holding register is empty. A word offered while it is full is ignored. A held word is taken at the start of the slot that uses it.
- R9: After reset `sdo_o`=0, `ws_o`=0, `urun_o`=0 and `smp_ready_o`=1.
- R10: `sdo_o`, `ws_o` and `urun_o` change only in the cycle after a `bit_tick_i` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bit_tick_i | input | 1 | One-cycle strobe per serial bit |
| len_code_i | input | 3 | Sample length code |
| slot24_i | input | 1 | 24-bit slot for codes 1-3 |
| fmt_lj_i | input | 1 | 1 left-justified, 0 I2S one-bit delay |
| mono_i | input | 1 | Repeat left sample in right slot |
| fill_prev_i | input | 1 | Underrun fill: 1 previous word, 0 zero |
| loop_i | input | 1 | Route serial output to receive input |
| smp_valid_i | input | 1 | Sample word offered |
| smp_data_i | input | 32 | Sample word |
| smp_ready_o | output | 1 | Holding register empty |
| sdo_o | output | 1 | Serial data |
| ws_o | output | 1 | Word select, 0 left, 1 right |
| urun_o | output | 1 | Underrun strobe |
| urun_slot_o | output | 1 | Slot index of the underrun |
| sdi_i | input | 1 | External serial input |
| rx_sdi_o | output | 1 | Serial input toward the receiver |

## Verification
The hardest case to reach is a holding register that changes between empty and full right at a slot boundary. Examples are a word accepted in the same cycle as the slot start that underruns, and a previous-word fill that follows a packed or mono right slot. The stimulus reaches these with sparse random offers and random bit-strobe spacing, so slot starts often meet an empty register. A directed sweep runs every length code in both formats, and randomly drawn configurations run after it. Each configuration is compared bit by bit against a frame model in the bench.

// File: rtl/atx_pkg.sv
package atx_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned POS_W  = $clog2(WORD_W) + 1;
    localparam int unsigned CODE_W = 3;

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [CODE_W-1:0] {
        LEN_32    = 3'd0,
        LEN_24    = 3'd1,
        LEN_20    = 3'd2,
        LEN_18    = 3'd3,
        LEN_16    = 3'd4,
        LEN_16_PK = 3'd5,
        LEN_8     = 3'd6,
        LEN_8_PK  = 3'd7
    } len_code_e;

    typedef struct packed {
        pos_t  pos;
        logic  slot;
        word_t cur;
        word_t right;
        word_t hold;
        logic  full;
        logic  sdo;
        logic  ws;
        logic  urun;
        logic  uslot;
    } tx_state_t;

    function automatic pos_t sample_bits(len_code_e c);
        case (c)
            LEN_32:              return pos_t'(32);
            LEN_24:              return pos_t'(24);
            LEN_20:              return pos_t'(20);
            LEN_18:              return pos_t'(18);
            LEN_16, LEN_16_PK:   return pos_t'(16);
            default:             return pos_t'(8);
        endcase
    endfunction

    function automatic pos_t slot_bits(len_code_e c, logic wide24);
        case (c)
            LEN_32:                 return pos_t'(32);
            LEN_24, LEN_20, LEN_18: return wide24 ? pos_t'(24) : pos_t'(32);
            LEN_16, LEN_16_PK:      return pos_t'(16);
            default:                return pos_t'(8);
        endcase
    endfunction

    function automatic logic is_packed(len_code_e c);
        return (c == LEN_16_PK) || (c == LEN_8_PK);
    endfunction
endpackage

// File: rtl/atx_word_sel.sv
module atx_word_sel
    import atx_pkg::*;
(
    input  logic      slot_i,
    input  word_t     hold_i,
    input  logic      full_i,
    input  word_t     right_i,
    input  word_t     last_i,
    input  len_code_e code_i,
    input  logic      mono_i,
    input  logic      fill_prev_i,
    output word_t     word_o,
    output word_t     right_o,
    output logic      take_o,
    output logic      urun_o
);
    logic  pk;
    logic  reuse;
    word_t fill;
    pos_t  len;

    always_comb begin
        pk    = is_packed(code_i);
        len   = sample_bits(code_i);
        reuse = slot_i && (mono_i || pk);
        fill  = fill_prev_i ? last_i : '0;
        word_o  = '0;
        right_o = right_i;
        take_o  = 1'b0;
        urun_o  = 1'b0;
        if (reuse) begin
            word_o = right_i;
        end else if (full_i) begin
            take_o = 1'b1;
            word_o = hold_i;
            if (!slot_i) begin
                if (mono_i)  right_o = hold_i;
                else if (pk) right_o = hold_i >> len;
            end
        end else begin
            urun_o = 1'b1;
            word_o = fill;
            if (!slot_i) right_o = fill;
        end
    end

    always_comb begin
        assert_take_xor_urun_R6: assert (!(take_o && urun_o));
    end
endmodule

// File: rtl/atx_bit_pick.sv
module atx_bit_pick
    import atx_pkg::*;
(
    input  word_t word_new_i,
    input  word_t word_old_i,
    input  pos_t  pos_i,
    input  pos_t  slot_len_i,
    input  pos_t  samp_len_i,
    input  logic  lj_i,
    output logic  bit_o
);
    localparam int unsigned IDX_W = $clog2(WORD_W);

    word_t src;
    pos_t  k;
    pos_t  idx;

    always_comb begin
        if (lj_i) begin
            src = word_new_i;
            k   = pos_i;
        end else if (pos_i == '0) begin
            src = word_old_i;
            k   = slot_len_i - pos_t'(1);
        end else begin
            src = word_new_i;
            k   = pos_i - pos_t'(1);
        end
        idx   = samp_len_i - pos_t'(1) - k;
        bit_o = (k < samp_len_i) ? src[idx[IDX_W-1:0]] : 1'b0;
    end
endmodule

// File: rtl/atx_frame_tx.sv
module atx_frame_tx
    import atx_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        bit_tick_i,
    input  logic [2:0]  len_code_i,
    input  logic        slot24_i,
    input  logic        fmt_lj_i,
    input  logic        mono_i,
    input  logic        fill_prev_i,
    input  logic        loop_i,
    input  logic        smp_valid_i,
    input  logic [31:0] smp_data_i,
    output logic        smp_ready_o,
    output logic        sdo_o,
    output logic        ws_o,
    output logic        urun_o,
    output logic        urun_slot_o,
    input  logic        sdi_i,
    output logic        rx_sdi_o
);
    tx_state_t st_q, st_d;
    len_code_e code;
    pos_t      slen, plen;
    word_t     sel_word, sel_right, eff_word;
    logic      sel_take, sel_urun, pick_bit, slot_start;

    assign code       = len_code_e'(len_code_i);
    assign slen       = slot_bits(code, slot24_i);
    assign plen       = sample_bits(code);
    assign slot_start = (st_q.pos == '0);
    assign eff_word   = slot_start ? sel_word : st_q.cur;

    atx_word_sel u_sel (
        .slot_i      (st_q.slot),
        .hold_i      (st_q.hold),
        .full_i      (st_q.full),
        .right_i     (st_q.right),
        .last_i      (st_q.cur),
        .code_i      (code),
        .mono_i      (mono_i),
        .fill_prev_i (fill_prev_i),
        .word_o      (sel_word),
        .right_o     (sel_right),
        .take_o      (sel_take),
        .urun_o      (sel_urun)
    );

    atx_bit_pick u_pick (
        .word_new_i (eff_word),
        .word_old_i (st_q.cur),
        .pos_i      (st_q.pos),
        .slot_len_i (slen),
        .samp_len_i (plen),
        .lj_i       (fmt_lj_i),
        .bit_o      (pick_bit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.urun = 1'b0;
        if (smp_valid_i && !st_q.full) begin
            st_d.hold = smp_data_i;
            st_d.full = 1'b1;
        end
        if (bit_tick_i) begin
            if (slot_start) begin
                st_d.cur   = sel_word;
                st_d.right = sel_right;
                st_d.urun  = sel_urun;
                st_d.uslot = st_q.slot;
                if (sel_take) st_d.full = 1'b0;
            end
            st_d.sdo = pick_bit;
            st_d.ws  = st_q.slot;
            if (st_q.pos == slen - pos_t'(1)) begin
                st_d.pos  = '0;
                st_d.slot = ~st_q.slot;
            end else begin
                st_d.pos = st_q.pos + pos_t'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign smp_ready_o = !st_q.full;
    assign sdo_o       = st_q.sdo;
    assign ws_o        = st_q.ws;
    assign urun_o      = st_q.urun;
    assign urun_slot_o = st_q.uslot;
    assign rx_sdi_o    = loop_i ? st_q.sdo : sdi_i;

    assert_accept_fills_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smp_valid_i && smp_ready_o) |=> !smp_ready_o);
    assert_ws_steady_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bit_tick_i |=> $stable(ws_o));
    assert_sdo_steady_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bit_tick_i |=> $stable(sdo_o));
    assert_urun_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bit_tick_i |=> !urun_o);
    assert_urun_slot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        urun_o |-> (urun_slot_o == ws_o));
    assert_zero_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (urun_o && !fill_prev_i && fmt_lj_i) |-> !sdo_o);
    assert_loop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        loop_i |-> (rx_sdi_o == sdo_o));
endmodule

// File: tb/tb_atx_frame_tx.sv
module tb_atx_frame_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [2:0]  code = 3'd0;
    logic        s24 = 1'b0, lj = 1'b0, mono = 1'b0, fprev = 1'b0, loop = 1'b0;
    logic        vld = 1'b0;
    logic [31:0] dat = '0;
    logic        sdi = 1'b0;
    logic        rdy, sdo, ws, urun, uslot, rxsdi;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    atx_frame_tx dut (
        .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .len_code_i(code),
        .slot24_i(s24), .fmt_lj_i(lj), .mono_i(mono), .fill_prev_i(fprev),
        .loop_i(loop), .smp_valid_i(vld), .smp_data_i(dat), .smp_ready_o(rdy),
        .sdo_o(sdo), .ws_o(ws), .urun_o(urun), .urun_slot_o(uslot),
        .sdi_i(sdi), .rx_sdi_o(rxsdi)
    );

    // frame model state
    int          m_pos, m_slot;
    logic [31:0] m_cur, m_right, m_hold;
    bit          m_full;
    bit          e_sdo, e_ws, e_urun, e_uslot;

    function automatic int len_of(logic [2:0] c);
        int t[8] = '{32, 24, 20, 18, 16, 16, 8, 8};
        return t[c];
    endfunction

    function automatic int slot_of(logic [2:0] c, logic w24);
        if (c == 0) return 32;
        if (c <= 3) return w24 ? 24 : 32;
        if (c <= 5) return 16;
        return 8;
    endfunction

    function automatic bit bit_at(logic [31:0] w, int k, int l);
        if (k >= l) return 1'b0;
        return w[l-1-k];
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pos = 0; m_slot = 0; m_cur = '0; m_right = '0; m_hold = '0; m_full = 0;
        e_sdo = 0; e_ws = 0; e_urun = 0; e_uslot = 0;
    endtask

    task automatic model_step();
        int L, W, k;
        bit pk, acc, take;
        logic [31:0] wnew, src, fill;
        L = len_of(code); W = slot_of(code, s24);
        pk = (code == 5) || (code == 7);
        acc = vld && !m_full;
        take = 0;
        e_urun = 0;
        if (tick) begin
            wnew = m_cur;
            if (m_pos == 0) begin
                fill = fprev ? m_cur : 32'd0;
                if (m_slot == 1 && (mono || pk)) wnew = m_right;
                else if (m_full) begin
                    take = 1; wnew = m_hold;
                    if (m_slot == 0) m_right = mono ? m_hold : (pk ? (m_hold >> L) : m_right);
                end else begin
                    e_urun = 1; e_uslot = m_slot[0]; wnew = fill;
                    if (m_slot == 0) m_right = fill;
                end
            end
            if (lj) begin src = wnew; k = m_pos; end
            else if (m_pos == 0) begin src = m_cur; k = W - 1; end
            else begin src = wnew; k = m_pos - 1; end
            e_sdo = bit_at(src, k, L);
            e_ws = m_slot[0];
            m_cur = wnew;
            if (m_pos == W - 1) begin m_pos = 0; m_slot = 1 - m_slot; end
            else m_pos++;
        end
        if (acc) begin m_hold = dat; m_full = 1; end
        else if (take) m_full = 0;
    endtask

    task automatic run_phase(int cycles);
        bit prev_tick = 0;
        bit p_sdo, p_ws;
        rst_n = 1'b0; tick = 0; vld = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        // R9: reset state
        check("R9", "sdo after reset", sdo, 0);
        check("R9", "ws after reset", ws, 0);
        check("R9", "urun after reset", urun, 0);
        check("R9", "ready after reset", rdy, 1);
        p_sdo = sdo; p_ws = ws;
        for (int c = 0; c < cycles; c++) begin
            tick = ($urandom_range(0, 2) == 0);
            vld  = ($urandom_range(0, 40) == 0);
            dat  = $urandom;
            sdi  = $urandom_range(0, 1);
            prev_tick = tick;
            model_step();
            @(negedge clk);
            check("R1/R3/R4/R5/R6", "sdo bit", sdo, e_sdo);
            check("R2", "ws", ws, e_ws);
            check("R6", "underrun strobe", urun, e_urun);
            if (e_urun) check("R6", "underrun slot", uslot, e_uslot);
            check("R8", "ready", rdy, !m_full);
            check("R7", "rx serial input", rxsdi, loop ? sdo : sdi);
            if (!prev_tick) begin
                check("R10", "sdo held", sdo, p_sdo);
                check("R10", "ws held", ws, p_ws);
            end
            p_sdo = sdo; p_ws = ws;
        end
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_a0d1));
        // directed sweep: every code, both formats
        for (int c = 0; c < 16; c++) begin
            code = 3'(c % 8); lj = (c >= 8); s24 = code[0];
            mono = (code == 4) || (code == 7); fprev = code[1]; loop = c[0];
            run_phase(1500);
        end
        // random configurations
        for (int r = 0; r < 14; r++) begin
            code = 3'($urandom_range(0, 7)); lj = $urandom_range(0, 1);
            s24 = $urandom_range(0, 1); mono = $urandom_range(0, 1);
            fprev = $urandom_range(0, 1); loop = $urandom_range(0, 1);
            run_phase(1500);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule